// File: doc/BRIEF.md
# Segmented RAM Write Protection Unit

This unit sits in front of a RAM write port and judges every store against two programmable address segments. Each segment is defined by an inclusive start word address, an exclusive end word address and a two-bit enable field. One enable bit applies to user-data stores and the other to supervisor-data stores. A global mode input picks the meaning of the segments. In block mode a segment marks a forbidden range. In allow-list mode the segments are the only ranges that may be written. While every enable field is zero, no store is checked.

A rejected store has its write strobe removed in the same cycle. In the next cycle the unit raises a one-cycle error pulse and keeps the full byte address of the offending store. A small register port loads and reads back the segment registers. When a value with bits set outside the legal fields is written, the port flags it with an error pulse.

Checking is tracked by a three-state controller. `ST_OPEN` means no enable field is set and every store passes. `ST_GUARD` means checking is active. `ST_FAULT` is the cycle after a rejection, in which the error pulse is driven. The transitions are:
- Open-to-guard: an enable field becomes nonzero.
- Guard-to-open: all enable fields return to zero.
- Guard-to-fault: a store is rejected.
- Fault-to-fault: another store is rejected at once.
- Fault-to-guard or fault-to-open: the next cycle has no rejection. Which of the two depends on whether any enable field is still set.

Top module: `segwp_unit`

## Requirements
- R1: After reset, every segment register reads zero and checking is off. `prot_err` and `cfg_err` are low and `fault_addr` is zero.
- R2: Register select `cfg_sel` works as follows. Bit 1 picks the segment. Bit 0 picks the register: 0 is the start register and 1 is the end register. A start register keeps the word address in bits 22:0 and the enable field in bits 24:23. Bit 23 enables checks on user-data stores (space code 0x0A) and bit 24 on supervisor-data stores (space code 0x0B). An end register keeps bits 22:0. `cfg_rdata` returns the selected register in the same layout, with all other bits zero, in the same cycle.
- R3: A register write raises `cfg_err` for exactly the following cycle in two cases: a start register written with any of bits 31:25 set, or an end register written with any of bits 31:23 set. The legal fields are still stored.
- R4: While both enable fields are zero, `wr_allow` equals `wr_en` in either mode and `prot_err` stays low.
- R5: The store word address is bits 24:2 of the byte address. A segment hits when all three conditions hold: the store's space code selects a set enable bit, the word is at least the start, and the word with bit 0 ORed with `wr_dword` is strictly below the end. Other space codes never hit.
- R6: With `blk_mode` high, a store that hits any segment is rejected.
- R7: With `blk_mode` low and checking on, a store that hits no segment is rejected.
- R8: A rejected store drives `wr_allow` low in its own cycle. `prot_err` is high during exactly the next cycle, and from then `fault_addr` holds the store's full byte address until the next rejection.
- R9: A register write changes the verdict for stores presented from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mode | input | 1 | 1: segments are forbidden ranges; 0: segments are the only writable ranges |
| wr_en | input | 1 | Store request strobe |
| wr_addr | input | 32 | Store byte address |
| wr_space | input | 8 | Access-space code of the store |
| wr_dword | input | 1 | Store is a double word |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: bit 1 segment, bit 0 start/end |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| cfg_err | output | 1 | Illegal register write pulse |
| wr_allow | output | 1 | Store may reach memory |
| prot_err | output | 1 | Protection error pulse |
| fault_addr | output | 32 | Byte address of the last rejected store |

## Verification
The assertions check four properties on every cycle. The open state never coexists with a set enable field. A permitted store always had a request. Every error pulse follows a request that was refused, and carries that request's address. A block-mode hit is never let through.

Only the bench's scenarios can show the following:
- The exact hit boundaries, including the end-exclusive compare, the double-word widening and the masking of address bits above 24.
- The split between user and supervisor enables.
- That illegal register bits are dropped while legal fields are kept.
- That a configuration change takes effect on the very next store.

// File: rtl/segwp_pkg.sv
package segwp_pkg;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_GUARD = 2'd1,
        ST_FAULT = 2'd2
    } guard_state_e;

    localparam logic [7:0] SPACE_USER = 8'h0A;
    localparam logic [7:0] SPACE_SUPV = 8'h0B;

    localparam int EN_W = 2;

endpackage

// File: rtl/segwp_cfg_bank.sv
module segwp_cfg_bank #(
    parameter int NSEG   = 2,
    parameter int WORD_W = 23,
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(NSEG) + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [SEL_W-1:0]                   cfg_sel,
    input  logic [DATA_W-1:0]                  cfg_wdata,
    output logic [DATA_W-1:0]                  cfg_rdata,
    output logic                               cfg_err,
    output logic [NSEG-1:0][WORD_W-1:0]        seg_lo,
    output logic [NSEG-1:0][WORD_W-1:0]        seg_hi,
    output logic [NSEG-1:0][segwp_pkg::EN_W-1:0] seg_en,
    output logic                               any_en,
    output logic                               any_en_nxt
);
    import segwp_pkg::*;

    localparam int SEG_IW   = SEL_W - 1;
    localparam int START_W  = WORD_W + EN_W;
    localparam int START_PAD = DATA_W - START_W;
    localparam int END_PAD  = DATA_W - WORD_W;

    logic [SEG_IW-1:0] seg_idx;
    logic              pick_end;
    logic              bad_bits;
    logic [NSEG-1:0]   en_nz;
    logic [NSEG-1:0]   en_nz_nxt;

    assign seg_idx  = cfg_sel[SEL_W-1:1];
    assign pick_end = cfg_sel[0];
    assign bad_bits = pick_end ? (|cfg_wdata[DATA_W-1:WORD_W])
                               : (|cfg_wdata[DATA_W-1:START_W]);

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic hit_start;
        logic hit_end;

        assign hit_start = cfg_we && (seg_idx == SEG_IW'(s)) && !pick_end;
        assign hit_end   = cfg_we && (seg_idx == SEG_IW'(s)) &&  pick_end;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_lo[s] <= '0;
                seg_en[s] <= '0;
            end else if (hit_start) begin
                seg_lo[s] <= cfg_wdata[WORD_W-1:0];
                seg_en[s] <= cfg_wdata[START_W-1:WORD_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_hi[s] <= '0;
            end else if (hit_end) begin
                seg_hi[s] <= cfg_wdata[WORD_W-1:0];
            end
        end

        assign en_nz[s]     = |seg_en[s];
        assign en_nz_nxt[s] = hit_start ? (|cfg_wdata[START_W-1:WORD_W]) : en_nz[s];
    end

    assign any_en     = |en_nz;
    assign any_en_nxt = |en_nz_nxt;

    always_comb begin
        cfg_rdata = '0;
        if (pick_end) begin
            cfg_rdata = {{END_PAD{1'b0}}, seg_hi[seg_idx]};
        end else begin
            cfg_rdata = {{START_PAD{1'b0}}, seg_en[seg_idx], seg_lo[seg_idx]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= cfg_we && bad_bits;
        end
    end

    // R3
    cfg_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we));

endmodule

// File: rtl/segwp_seg_match.sv
module segwp_seg_match #(
    parameter int WORD_W = 23
) (
    input  logic              [WORD_W-1:0] word,
    input  logic                           dword,
    input  logic                           is_user,
    input  logic                           is_supv,
    input  logic              [WORD_W-1:0] lo,
    input  logic              [WORD_W-1:0] hi,
    input  logic [segwp_pkg::EN_W-1:0]     en,
    output logic                           hit
);
    logic              space_ok;
    logic [WORD_W-1:0] top_word;
    logic              above_lo;
    logic              below_hi;

    assign space_ok = (en[0] && is_user) || (en[1] && is_supv);
    assign top_word = {word[WORD_W-1:1], word[0] | dword};
    assign above_lo = (word >= lo);
    assign below_hi = (top_word < hi);
    assign hit      = space_ok && above_lo && below_hi;

endmodule

// File: rtl/segwp_guard_fsm.sv
module segwp_guard_fsm #(
    parameter int NSEG   = 2,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NSEG-1:0]   hits,
    input  logic              any_en,
    input  logic              any_en_nxt,
    output logic              wr_allow,
    output logic              prot_err,
    output logic [ADDR_W-1:0] fault_addr
);
    import segwp_pkg::*;

    guard_state_e state;
    guard_state_e state_nxt;
    logic         gate;
    logic         violation;
    logic         reject;

    assign violation = blk_mode ? (|hits) : !(|hits);
    assign reject    = wr_en && gate && violation;
    assign wr_allow  = wr_en && !reject;

    always_comb begin
        if (reject) begin
            state_nxt = ST_FAULT;
        end else if (any_en_nxt) begin
            state_nxt = ST_GUARD;
        end else begin
            state_nxt = ST_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        gate     = 1'b0;
        prot_err = 1'b0;
        unique case (state)
            ST_OPEN: begin
                gate     = 1'b0;
                prot_err = 1'b0;
            end
            ST_GUARD: begin
                gate     = 1'b1;
                prot_err = 1'b0;
            end
            ST_FAULT: begin
                gate     = any_en;
                prot_err = 1'b1;
            end
            default: begin
                gate     = 1'b0;
                prot_err = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_addr <= '0;
        end else if (reject) begin
            fault_addr <= wr_addr;
        end
    end

    // R4
    open_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |-> !any_en);

    // R8
    allow_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> wr_en);

    // R8
    err_follows_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> ($past(wr_en) && !$past(wr_allow)));

    // R8
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> (fault_addr == $past(wr_addr)));

endmodule

// File: rtl/segwp_unit.sv
module segwp_unit #(
    parameter int NSEG   = 2,
    parameter int WORD_W = 23,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(NSEG) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_space,
    input  logic              wr_dword,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_err,
    output logic              wr_allow,
    output logic              prot_err,
    output logic [ADDR_W-1:0] fault_addr
);
    import segwp_pkg::*;

    logic [NSEG-1:0][WORD_W-1:0] seg_lo;
    logic [NSEG-1:0][WORD_W-1:0] seg_hi;
    logic [NSEG-1:0][EN_W-1:0]   seg_en;
    logic                        any_en;
    logic                        any_en_nxt;
    logic [NSEG-1:0]             hits;
    logic [WORD_W-1:0]           word;
    logic                        is_user;
    logic                        is_supv;

    assign word    = wr_addr[WORD_W+1:2];
    assign is_user = (wr_space == SPACE_USER);
    assign is_supv = (wr_space == SPACE_SUPV);

    segwp_cfg_bank #(
        .NSEG   (NSEG),
        .WORD_W (WORD_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_err    (cfg_err),
        .seg_lo     (seg_lo),
        .seg_hi     (seg_hi),
        .seg_en     (seg_en),
        .any_en     (any_en),
        .any_en_nxt (any_en_nxt)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_match
        segwp_seg_match #(
            .WORD_W (WORD_W)
        ) u_match (
            .word    (word),
            .dword   (wr_dword),
            .is_user (is_user),
            .is_supv (is_supv),
            .lo      (seg_lo[s]),
            .hi      (seg_hi[s]),
            .en      (seg_en[s]),
            .hit     (hits[s])
        );
    end

    segwp_guard_fsm #(
        .NSEG   (NSEG),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_mode   (blk_mode),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .hits       (hits),
        .any_en     (any_en),
        .any_en_nxt (any_en_nxt),
        .wr_allow   (wr_allow),
        .prot_err   (prot_err),
        .fault_addr (fault_addr)
    );

    // R6
    blk_hit_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && wr_en && (|hits)) |-> !wr_allow);

endmodule

// File: tb/test_segwp_unit.sv
`timescale 1ns/1ps
module test_segwp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [7:0]  wr_space = '0;
    logic        wr_dword = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        wr_allow;
    logic        prot_err;
    logic [31:0] fault_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    segwp_unit i_segwp_unit (
        .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_space(wr_space), .wr_dword(wr_dword),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .wr_allow(wr_allow),
        .prot_err(prot_err), .fault_addr(fault_addr)
    );

    // {blk, space, dword, byte addr, expected allow}
    localparam logic [42:0] VEC [15] = '{
        {1'b1, 8'h0A, 1'b0, 32'h0000_0400, 1'b0},
        {1'b1, 8'h0A, 1'b0, 32'h0000_03FC, 1'b1},
        {1'b1, 8'h0A, 1'b0, 32'h0000_07FC, 1'b0},
        {1'b1, 8'h0A, 1'b0, 32'h0000_0800, 1'b1},
        {1'b1, 8'h0A, 1'b1, 32'h0000_07F8, 1'b0},
        {1'b1, 8'h0B, 1'b0, 32'h0000_0540, 1'b1},
        {1'b1, 8'h0B, 1'b0, 32'h0000_4020, 1'b0},
        {1'b1, 8'h09, 1'b0, 32'h0000_4020, 1'b1},
        {1'b1, 8'h0A, 1'b0, 32'h0200_0400, 1'b0},
        {1'b0, 8'h0A, 1'b0, 32'h0000_0540, 1'b1},
        {1'b0, 8'h0B, 1'b0, 32'h0000_0540, 1'b0},
        {1'b0, 8'h0B, 1'b0, 32'h0000_403C, 1'b1},
        {1'b0, 8'h0B, 1'b1, 32'h0000_4038, 1'b1},
        {1'b0, 8'h09, 1'b0, 32'h0000_0540, 1'b0},
        {1'b0, 8'h0A, 1'b0, 32'h0000_0800, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] val);
        cfg_sel = sel;
        #1 val = cfg_rdata;
    endtask

    // called at a negedge; returns at the following negedge
    task automatic run_wr(input logic blk, input logic [7:0] sp, input logic dw,
                          input logic [31:0] a, output logic got);
        blk_mode = blk; wr_space = sp; wr_dword = dw; wr_addr = a; wr_en = 1'b1;
        #1 got = wr_allow;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %h expected %h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        got;
        logic [42:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            cfg_read(2'(s), rd);
            chk("R1 reg zero", rd, 32'h0);
        end
        chk("R1 prot_err", {31'b0, prot_err}, 32'h0);
        chk("R1 cfg_err", {31'b0, cfg_err}, 32'h0);
        chk("R1 fault_addr", fault_addr, 32'h0);
        run_wr(1'b0, 8'h0A, 1'b0, 32'h0000_0540, got);
        chk("R1 R4 allow while off", {31'b0, got}, 32'h1);
        chk("R4 no error while off", {31'b0, prot_err}, 32'h0);

        // R2 configuration and readback
        cfg_write(2'd0, 32'h0080_0100);
        chk("R2 legal write no cfg_err", {31'b0, cfg_err}, 32'h0);
        cfg_write(2'd1, 32'h0000_0200);
        cfg_write(2'd2, 32'h0180_1000);
        cfg_write(2'd3, 32'h0000_1010);
        cfg_read(2'd0, rd); chk("R2 start0", rd, 32'h0080_0100);
        cfg_read(2'd1, rd); chk("R2 end0", rd, 32'h0000_0200);
        cfg_read(2'd2, rd); chk("R2 start1", rd, 32'h0180_1000);
        cfg_read(2'd3, rd); chk("R2 end1", rd, 32'h0000_1010);

        // R5 R6 R7 R8 vector table
        for (int k = 0; k < 15; k++) begin
            v = VEC[k];
            run_wr(v[42], v[41:34], v[33], v[32:1], got);
            chk(v[42] ? "R5 R6 allow" : "R5 R7 allow", {31'b0, got}, {31'b0, v[0]});
            chk("R8 prot_err", {31'b0, prot_err}, {31'b0, ~v[0]});
            if (!v[0]) chk("R8 fault_addr", fault_addr, v[32:1]);
        end

        // R3 illegal register bits
        cfg_write(2'd3, 32'h0080_1010);
        chk("R3 end bit23 cfg_err", {31'b0, cfg_err}, 32'h1);
        cfg_read(2'd3, rd); chk("R3 end masked", rd, 32'h0000_1010);
        cfg_write(2'd2, 32'h0380_1000);
        chk("R3 start bit25 cfg_err", {31'b0, cfg_err}, 32'h1);
        cfg_read(2'd2, rd); chk("R3 start masked", rd, 32'h0180_1000);
        @(negedge clk);
        chk("R3 pulse one cycle", {31'b0, cfg_err}, 32'h0);

        // R8 fault address held over an allowed store
        run_wr(1'b1, 8'h0A, 1'b0, 32'h0000_0480, got);
        chk("R8 reject", {31'b0, got}, 32'h0);
        run_wr(1'b1, 8'h0A, 1'b0, 32'h0000_03FC, got);
        chk("R8 pulse ends", {31'b0, prot_err}, 32'h0);
        chk("R8 fault_addr held", fault_addr, 32'h0000_0480);

        // R4 checking off when both enable fields cleared
        cfg_write(2'd0, 32'h0000_0100);
        cfg_write(2'd2, 32'h0000_1000);
        run_wr(1'b0, 8'h0B, 1'b0, 32'h0000_0540, got);
        chk("R4 allow-list off", {31'b0, got}, 32'h1);
        chk("R4 no prot_err", {31'b0, prot_err}, 32'h0);

        // R9 new configuration applies on the very next store
        cfg_write(2'd2, 32'h0100_1000);
        run_wr(1'b0, 8'h0B, 1'b0, 32'h0000_0540, got);
        chk("R9 next-cycle reject", {31'b0, got}, 32'h0);
        chk("R9 prot_err", {31'b0, prot_err}, 32'h1);
        run_wr(1'b0, 8'h0A, 1'b0, 32'h0000_4020, got);
        chk("R9 user not enabled on seg1", {31'b0, got}, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule